// File: doc/BRIEF.md
# SPI Preselection Transaction Router

This block sits between a host SPI master and three downstream SPI slaves that share one clock line and one bidirectional data line (3-wire SPI). Each host transaction opens with an 8-bit destination byte. The block decodes that byte, then either serves its own small bank of three control registers or passes the rest of the transaction through to one downstream device, so that device's registers look as if they were wired directly to the host.

The block runs on a fast system clock and samples the host SCLK, chip select and data as ordinary inputs, finding SCLK edges by comparing against a registered copy. The tri-state pads sit outside the block. Each data line therefore appears as an input, an output and an output enable.

The three control registers drive board-level signals:
- clock-source and sync-source selects,
- an active-low reset for the clock device,
- an active-low reset shared by the converter devices,
- front-panel I/O direction bits,
- active-low fan enables.

Top module: `spi_presel_router`

## Requirements
- R1: The destination byte is shifted in MSB first on rising host SCLK edges. While it is being received, every downstream chip select stays high and the downstream SCLK stays low.
- R2: Destination 0x00 selects the local register bank. Destinations 0x82, 0x83 and 0x84 pull `dev_csn_o[0]`, `dev_csn_o[1]` and `dev_csn_o[2]` low respectively, starting only after the 8th destination bit, and never more than one at a time.
- R3: While forwarding, the downstream SCLK follows the host SCLK from the first falling edge after the destination byte, and `dev_sdio_o` carries the host data with `dev_sdio_oe_o` high.
- R4: If the first forwarded bit is 1 (a read), then after CMD_BITS (default 16) forwarded rising edges `dev_sdio_oe_o` goes low, `host_sdio_oe_o` goes high and `host_sdio_o` follows `dev_sdio_i`. A forwarded write keeps the host-to-device direction throughout.
- R5: A local access is one command byte followed by one data byte. Command bit 7 set means read; bits 6:0 are the register index. A write to an index above 2 changes nothing, and a read from such an index returns 0.
- R6: On a local read, `host_sdio_oe_o` is high during the data byte. The register value is driven MSB first, each bit updated on a falling host SCLK edge.
- R7: Register 0 bits 2:0 drive `clk_src_o` and bits 4:3 drive `sync_src_o`. Register 1 bit 0 set pulls `clkdev_rst_n_o` low and bit 1 set pulls `dac_rst_n_o` low. Register 2 bits 3:0 drive `io_dir_o`, and bits 7:4 set pull the matching `fan_en_n_o` bits low. Reads return all 8 stored bits.
- R8: A high host chip select at any time aborts the transaction. All downstream chip selects go high, both output enables go low, and a partly shifted local write is not committed.
- R9: An unrecognised destination byte selects no device and produces no downstream SCLK, and the rest of that transaction changes no register.
- R10: After reset all registers are zero. The fan enables and both reset outputs are therefore high, and both selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low synchronous reset |
| host_csn_i | input | 1 | Host chip select, active low |
| host_sclk_i | input | 1 | Host SPI clock |
| host_sdio_i | input | 1 | Host data line, incoming value |
| host_sdio_o | output | 1 | Host data line, value driven back |
| host_sdio_oe_o | output | 1 | Drive enable for the host data line |
| dev_csn_o | output | 3 | Downstream chip selects, active low |
| dev_sclk_o | output | 1 | Gated downstream SPI clock |
| dev_sdio_i | input | 1 | Downstream data line, incoming value |
| dev_sdio_o | output | 1 | Downstream data line, value driven |
| dev_sdio_oe_o | output | 1 | Drive enable for the downstream data line |
| clk_src_o | output | 3 | Clock-source select |
| sync_src_o | output | 2 | Sync-source select |
| clkdev_rst_n_o | output | 1 | Clock device reset, active low |
| dac_rst_n_o | output | 1 | Shared converter reset, active low |
| io_dir_o | output | 4 | Front-panel I/O direction |
| fan_en_n_o | output | 4 | Fan enables, active low |

## Verification
Two events can coincide:
- the 8th destination bit, which opens a downstream chip select, can land on the same SCLK rise as the gating of the downstream clock;
- a host chip-select release can land in the same cycle as a pending local register commit.

The bench provokes the first by checking `dev_sclk_o` and the chip selects on the very rise that completes the destination byte. The expected outcome is that no downstream rising edge appears until the following falling edge. The bench provokes the second by raising chip select after 7 of 8 data bits. It then judges the abort by reading the register back and comparing it with the bench's own model.

// File: rtl/spi_router_pkg.sv
package spi_router_pkg;
  typedef enum logic [2:0] {
    ST_PRESEL,
    ST_LCMD,
    ST_LWR,
    ST_LRD,
    ST_FWD,
    ST_SKIP
  } rt_state_e;

  localparam int          NUM_DEV    = 3;
  localparam int          NUM_REGS   = 3;
  localparam int          BYTE_W     = 8;
  localparam logic [7:0]  CODE_LOCAL = 8'h00;
  localparam logic [7:0]  CODE_DEV0  = 8'h82;
endpackage

// File: rtl/spi_router_decode.sv
module spi_router_decode #(
  parameter int         NDEV       = 3,
  parameter logic [7:0] LOCAL_CODE = 8'h00,
  parameter logic [7:0] DEV_BASE   = 8'h82
) (
  input  logic [7:0]      code_i,
  output logic            local_hit_o,
  output logic [NDEV-1:0] dev_hit_o
);
  assign local_hit_o = (code_i == LOCAL_CODE);

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    localparam logic [7:0] MY_CODE = DEV_BASE + 8'(g);
    assign dev_hit_o[g] = (code_i == MY_CODE);
  end
endmodule

// File: rtl/spi_router_regs.sv
module spi_router_regs #(
  parameter int NREG = 3,
  parameter int W    = 8,
  parameter int IW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o,
  output logic [2:0]    clk_src_o,
  output logic [1:0]    sync_src_o,
  output logic          clkdev_rst_n_o,
  output logic          dac_rst_n_o,
  output logic [3:0]    io_dir_o,
  output logic [3:0]    fan_en_n_o
);
  logic [W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                 bank[g] <= '0;
      else if (we_i && (widx_i == IW'(g)))        bank[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (ridx_i == IW'(i)) rdata_o = bank[i];
  end

  assign clk_src_o      = bank[0][2:0];
  assign sync_src_o     = bank[0][4:3];
  assign clkdev_rst_n_o = ~bank[1][0];
  assign dac_rst_n_o    = ~bank[1][1];
  assign io_dir_o       = bank[2][3:0];
  assign fan_en_n_o     = ~bank[2][7:4];
endmodule

// File: rtl/spi_router_ctrl.sv
module spi_router_ctrl
  import spi_router_pkg::*;
#(
  parameter int NDEV     = 3,
  parameter int CMD_BITS = 16,
  parameter int IW       = 7,
  localparam int CW      = $clog2(CMD_BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_csn_i,
  input  logic            host_sclk_i,
  input  logic            host_sdi_i,
  input  logic [7:0]      rdata_i,
  output logic            we_o,
  output logic [IW-1:0]   widx_o,
  output logic [7:0]      wdata_o,
  output logic [IW-1:0]   ridx_o,
  output logic [NDEV-1:0] sel_o,
  output logic            gate_o,
  output logic            turn_o,
  output logic            lrd_o,
  output logic            lout_o
);
  rt_state_e      st;
  logic           sclk_q, rise, fall;
  logic [7:0]     shreg, cmd, osh, nxt;
  logic [2:0]     bcnt;
  logic [CW-1:0]  fcnt;
  logic           rdflag, rd_now;
  logic           local_hit;
  logic [NDEV-1:0] dev_hit;

  assign rise   = host_sclk_i & ~sclk_q;
  assign fall   = ~host_sclk_i & sclk_q;
  assign nxt    = {shreg[6:0], host_sdi_i};
  assign rd_now = (fcnt == '0) ? host_sdi_i : rdflag;

  spi_router_decode #(
    .NDEV(NDEV), .LOCAL_CODE(CODE_LOCAL), .DEV_BASE(CODE_DEV0)
  ) u_dec (
    .code_i(nxt), .local_hit_o(local_hit), .dev_hit_o(dev_hit)
  );

  assign we_o    = (st == ST_LWR) && rise && (bcnt == 3'd7) && !host_csn_i;
  assign widx_o  = cmd[IW-1:0];
  assign wdata_o = nxt;
  assign ridx_o  = nxt[IW-1:0];
  assign lrd_o   = (st == ST_LRD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_PRESEL; sclk_q <= 1'b0; shreg <= '0; cmd <= '0; osh <= '0;
      bcnt <= '0; fcnt <= '0; rdflag <= 1'b0; turn_o <= 1'b0;
      sel_o <= '0; gate_o <= 1'b0; lout_o <= 1'b0;
    end else begin
      sclk_q <= host_sclk_i;
      if (host_csn_i) begin
        st <= ST_PRESEL; bcnt <= '0; fcnt <= '0; rdflag <= 1'b0;
        turn_o <= 1'b0; sel_o <= '0; gate_o <= 1'b0;
      end else begin
        if (rise) begin
          unique case (st)
            ST_PRESEL: begin
              shreg <= nxt;
              bcnt  <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                if (local_hit)     st <= ST_LCMD;
                else if (|dev_hit) begin st <= ST_FWD; sel_o <= dev_hit; end
                else               st <= ST_SKIP;
              end
            end
            ST_LCMD: begin
              shreg <= nxt;
              bcnt  <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                cmd <= nxt;
                if (nxt[7]) begin st <= ST_LRD; osh <= rdata_i; end
                else        st <= ST_LWR;
              end
            end
            ST_LWR: begin
              shreg <= nxt;
              bcnt  <= bcnt + 3'd1;
              if (bcnt == 3'd7) st <= ST_SKIP;
            end
            ST_LRD: begin
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) st <= ST_SKIP;
            end
            ST_FWD: begin
              if (fcnt != CW'(CMD_BITS)) fcnt <= fcnt + CW'(1);
              if (fcnt == '0) rdflag <= host_sdi_i;
              if (fcnt == CW'(CMD_BITS - 1) && rd_now) turn_o <= 1'b1;
            end
            default: ;
          endcase
        end
        if (fall && st == ST_FWD) gate_o <= 1'b1;
        if (fall && st == ST_LRD) begin
          lout_o <= osh[7];
          osh    <= {osh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_presel_router.sv
module spi_presel_router
  import spi_router_pkg::*;
#(
  parameter int CMD_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_csn_i,
  input  logic       host_sclk_i,
  input  logic       host_sdio_i,
  output logic       host_sdio_o,
  output logic       host_sdio_oe_o,
  output logic [2:0] dev_csn_o,
  output logic       dev_sclk_o,
  input  logic       dev_sdio_i,
  output logic       dev_sdio_o,
  output logic       dev_sdio_oe_o,
  output logic [2:0] clk_src_o,
  output logic [1:0] sync_src_o,
  output logic       clkdev_rst_n_o,
  output logic       dac_rst_n_o,
  output logic [3:0] io_dir_o,
  output logic [3:0] fan_en_n_o
);
  localparam int IW = BYTE_W - 1;

  logic              we, gate, turn, lrd, lout;
  logic [IW-1:0]     widx, ridx;
  logic [7:0]        wdata, rdata;
  logic [NUM_DEV-1:0] sel;

  spi_router_ctrl #(.NDEV(NUM_DEV), .CMD_BITS(CMD_BITS), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_csn_i(host_csn_i), .host_sclk_i(host_sclk_i),
    .host_sdi_i(host_sdio_i), .rdata_i(rdata), .we_o(we), .widx_o(widx),
    .wdata_o(wdata), .ridx_o(ridx), .sel_o(sel), .gate_o(gate), .turn_o(turn),
    .lrd_o(lrd), .lout_o(lout)
  );

  spi_router_regs #(.NREG(NUM_REGS), .W(BYTE_W), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(we), .widx_i(widx), .wdata_i(wdata),
    .ridx_i(ridx), .rdata_o(rdata), .clk_src_o(clk_src_o), .sync_src_o(sync_src_o),
    .clkdev_rst_n_o(clkdev_rst_n_o), .dac_rst_n_o(dac_rst_n_o),
    .io_dir_o(io_dir_o), .fan_en_n_o(fan_en_n_o)
  );

  assign dev_csn_o      = ~(sel & {NUM_DEV{~host_csn_i}});
  assign dev_sclk_o     = host_sclk_i & gate & ~host_csn_i;
  assign dev_sdio_o     = host_sdio_i;
  assign dev_sdio_oe_o  = ~host_csn_i & (|sel) & ~turn;
  assign host_sdio_o    = turn ? dev_sdio_i : lout;
  assign host_sdio_oe_o = ~host_csn_i & (turn | lrd);
endmodule

// File: rtl/spi_router_chk.sv
module spi_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_csn,
  input logic [2:0] dev_csn,
  input logic       dev_sclk,
  input logic       host_oe,
  input logic       dev_oe,
  input logic [2:0] clk_src,
  input logic [3:0] fan_en_n
);
  AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~dev_csn)); // R2
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) !(host_oe && dev_oe)); // R4
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    host_csn |-> (dev_csn == 3'b111 && !host_oe && !dev_oe)); // R8
  AST_NO_STRAY_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_csn == 3'b111) |-> !dev_sclk); // R9
  AST_IDLE_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    host_csn |=> ($stable(clk_src) && $stable(fan_en_n))); // R8
endmodule

bind spi_presel_router spi_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_csn(host_csn_i), .dev_csn(dev_csn_o),
  .dev_sclk(dev_sclk_o), .host_oe(host_sdio_oe_o), .dev_oe(dev_sdio_oe_o),
  .clk_src(clk_src_o), .fan_en_n(fan_en_n_o)
);

// File: tb/sim_spi_presel_router.sv
`timescale 1ns/1ps
module sim_spi_presel_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0, dsdi = 1'b0;
  logic hso, hoe, dsclk, dso, doe, crst, drst;
  logic [2:0] dcsn, csrc;
  logic [1:0] ssrc;
  logic [3:0] iod, fan;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model [3];

  always #2.5 clk = ~clk;

  spi_presel_router u0 (
    .clk(clk), .rst_n(rst_n), .host_csn_i(csn), .host_sclk_i(sclk),
    .host_sdio_i(sdi), .host_sdio_o(hso), .host_sdio_oe_o(hoe), .dev_csn_o(dcsn),
    .dev_sclk_o(dsclk), .dev_sdio_i(dsdi), .dev_sdio_o(dso), .dev_sdio_oe_o(doe),
    .clk_src_o(csrc), .sync_src_o(ssrc), .clkdev_rst_n_o(crst), .dac_rst_n_o(drst),
    .io_dir_o(iod), .fan_en_n_o(fan)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_fields(input logic [7:0] r0, r1, r2);
    return {r0[2:0], r0[4:3], ~r1[0], ~r1[1], r2[3:0], ~r2[7:4]};
  endfunction

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_tx(input logic b);
    sclk = 1'b0; sdi = b; half();
    sclk = 1'b1; half();
  endtask

  task automatic byte_tx(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_tx(v[i]);
  endtask

  task automatic begin_tx();
    sclk = 1'b0; csn = 1'b0; half();
  endtask

  task automatic end_tx();
    sclk = 1'b0; half(); csn = 1'b1; half();
  endtask

  task automatic wr_reg(input logic [6:0] idx, input logic [7:0] v);
    begin_tx(); byte_tx(8'h00); byte_tx({1'b0, idx}); byte_tx(v); end_tx();
  endtask

  task automatic rd_reg(input logic [6:0] idx, output logic [7:0] v);
    begin_tx(); byte_tx(8'h00); byte_tx({1'b1, idx});
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; half();
      v[i] = hso;
      chk(hoe === 1'b1, "R6 oe during read", int'(hoe), 1);
      sclk = 1'b1; half();
    end
    end_tx();
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    for (int r = 0; r < 3; r++) begin
      rd_reg(7'(r), v);
      chk(v === model[r], tag, int'(v), int'(model[r]));
    end
    chk({csrc, ssrc, crst, drst, iod, fan} === exp_fields(model[0], model[1], model[2]),
        "R7 field map", int'({csrc, ssrc, crst, drst, iod, fan}),
        int'(exp_fields(model[0], model[1], model[2])));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, code;
    logic [6:0] idx;
    logic b;
    void'($urandom(32'd20240607));
    for (int r = 0; r < 3; r++) model[r] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; half();

    // R10 reset state
    chk({csrc, ssrc, crst, drst, iod, fan} === 16'h030F, "R10 reset outputs",
        int'({csrc, ssrc, crst, drst, iod, fan}), 16'h030F);
    chk(dcsn === 3'b111 && !hoe && !doe, "R10 idle selects", int'({dcsn, hoe, doe}), 8'h1C);

    // R5 R7 directed writes and reads
    wr_reg(7'd0, 8'h1D); model[0] = 8'h1D;
    wr_reg(7'd1, 8'h02); model[1] = 8'h02;
    wr_reg(7'd2, 8'hA5); model[2] = 8'hA5;
    check_all("R5 readback");
    wr_reg(7'd3, 8'hFF);
    check_all("R5 index 3 write ignored");
    rd_reg(7'd3, v);
    chk(v === 8'h00, "R5 index 3 reads zero", int'(v), 0);

    // random local traffic
    for (int k = 0; k < 24; k++) begin
      idx = 7'($urandom % 4);
      v   = 8'($urandom);
      wr_reg(idx, v);
      if (idx < 7'd3) model[idx[1:0]] = v;
    end
    check_all("R7 random readback");

    // R1 R2 R3 forwarded write to each device
    for (int d = 0; d < 3; d++) begin
      code = 8'h82 + 8'(d);
      begin_tx();
      for (int i = 7; i >= 1; i--) begin
        bit_tx(code[i]);
        chk(dcsn === 3'b111 && dsclk === 1'b0, "R1 no select during destination",
            int'({dcsn, dsclk}), 8'hE);
      end
      bit_tx(code[0]);
      chk(dcsn === ~(3'b001 << d), "R2 device select", int'(dcsn), int'(~(3'b001 << d) & 3'h7));
      chk(dsclk === 1'b0, "R3 no clock edge on destination rise", int'(dsclk), 0);
      for (int i = 0; i < 16; i++) begin
        b = (i == 0) ? 1'b0 : 1'($urandom);
        sclk = 1'b0; sdi = b; half();
        chk(dso === b && doe === 1'b1 && dsclk === 1'b0, "R3 forward data", int'({dso, doe, dsclk}), int'({b, 2'b10}));
        sclk = 1'b1; half();
        chk(dsclk === 1'b1, "R3 forward clock", int'(dsclk), 1);
      end
      chk(doe === 1'b1 && hoe === 1'b0, "R4 write keeps direction", int'({doe, hoe}), 2);
      end_tx();
      chk(dcsn === 3'b111, "R8 release after end", int'(dcsn), 7);
    end

    // R4 forwarded read with turnaround
    begin_tx(); byte_tx(8'h84);
    for (int i = 0; i < 16; i++) begin
      bit_tx(i == 0 ? 1'b1 : 1'($urandom));
      if (i == 14) chk(doe === 1'b1 && hoe === 1'b0, "R4 before turnaround", int'({doe, hoe}), 2);
    end
    chk(doe === 1'b0 && hoe === 1'b1, "R4 after turnaround", int'({doe, hoe}), 1);
    for (int i = 0; i < 8; i++) begin
      b = 1'($urandom);
      sclk = 1'b0; dsdi = b; half();
      chk(hso === b, "R4 read data to host", int'(hso), int'(b));
      sclk = 1'b1; half();
    end
    end_tx();
    chk(!hoe && !doe, "R8 oe released", int'({hoe, doe}), 0);

    // R8 abort mid local write
    begin_tx(); byte_tx(8'h00); byte_tx(8'h01);
    for (int i = 0; i < 7; i++) bit_tx(~model[1][7-i]);
    csn = 1'b1; half();
    chk(dcsn === 3'b111 && !hoe && !doe, "R8 abort release", int'({dcsn, hoe, doe}), 8'h1C);
    sclk = 1'b0; half();
    check_all("R8 aborted write not committed");

    // R9 unrecognised destinations
    for (int k = 0; k < 4; k++) begin
      do code = 8'($urandom);
      while (code == 8'h00 || code == 8'h82 || code == 8'h83 || code == 8'h84);
      begin_tx(); byte_tx(code);
      chk(dcsn === 3'b111, "R9 no device selected", int'(dcsn), 7);
      byte_tx(8'h00);
      byte_tx(8'hFF);
      chk(dsclk === 1'b0 && !hoe && !doe, "R9 no clock or drive", int'({dsclk, hoe, doe}), 0);
      end_tx();
    end
    check_all("R9 registers unchanged");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule